// File: doc/BRIEF.md
# Indirect Host Register Bridge

This block is a host-bus slave that sits in front of a network controller's internal register file and packet buffers. The host sees only four byte locations. These are a mode byte, two bytes that together form a pointer into the internal space, and a data port. Each host access to the data port becomes a single byte read or write on an internal port, at the location the pointer names. A 15-bit internal space can therefore be reached through a very small bus window.

When the auto-step option is set, every data-port access advances the pointer by one. Blocks of buffer memory and 16-bit registers can then be streamed with back-to-back data-port accesses. The pointer does not respect any buffer boundary inside the internal space. It only rolls over at the top of the 15-bit space, so a host that crosses the end of a ring buffer must load the pointer again itself.

A soft-reset bit in the mode byte returns the bridge to its defaults. It also holds a reset line to the internal logic for a fixed number of cycles and then clears itself. The internal side answers reads one cycle after the strobe. The bridge presents that byte to the host in the same cycle it presents register reads.

Top module: `ihb_bridge`

## Requirements
- R1: Host offset 0 selects the mode byte, offset 1 the pointer high byte, offset 2 the pointer low byte, and offset 3 the data port. A host read returns its byte on `host_rdata`, with `host_rvalid` high, in the cycle after the read strobe. The high byte reads back the pointer bits above bit 7, zero-extended, so its bit 7 always reads 0.
- R2: After `rst_n` is released, the mode byte reads 0x00, the pointer reads 0x0000, `ping_block` and `int_srst` are low, and no internal strobe is active.
- R3: Mode bit 4 is the ping-block option and drives `ping_block`. Bit 1 enables auto-step. Bit 0 selects indirect operation. Bits 6, 5, 3 and 2 always read 0.
- R4: In indirect operation (mode bit 0 = 1), a host write to offset 3 raises `int_we` for that one cycle, with `int_addr` equal to the pointer and `int_wdata` equal to the host byte.
- R5: In indirect operation, a host read of offset 3 raises `int_re` in the same cycle at the pointer address. The byte the internal port returns on the next cycle is what appears on `host_rdata`.
- R6: With auto-step set, each data-port access that reaches the internal port advances the pointer by exactly one. With auto-step clear, the pointer is unchanged.
- R7: The pointer is 15 bits wide. An auto-step from 0x7FFF gives 0x0000.
- R8: With mode bit 0 clear, data-port accesses raise no internal strobe, leave the pointer unchanged, and read as 0x00.
- R9: Writing a mode byte with bit 7 set clears the other mode bits and the pointer. It holds `int_srst` high for RST_CYCLES cycles. While `int_srst` is high, the mode byte reads 0x80. Afterwards it reads 0x00.
- R10: While `int_srst` is high, host writes to every offset are ignored and no internal strobe is raised.
- R11: When `host_wr` and `host_rd` are high in the same cycle, only the write takes effect and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ofs | input | 2 | Host byte offset within the window |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| int_addr | output | AW | Internal byte address (the pointer) |
| int_wdata | output | 8 | Internal write byte |
| int_we | output | 1 | Internal write strobe |
| int_re | output | 1 | Internal read strobe |
| int_rdata | input | 8 | Internal read byte, one cycle after int_re |
| int_srst | output | 1 | Soft reset toward the internal logic |
| ping_block | output | 1 | Ping-block option from the mode byte |

## Verification
A wrong pointer shows up on `int_addr` at the very next data-port strobe. It also shows up on the pointer bytes one cycle after the host reads them. A lost or extra step shifts every later byte of a streamed transfer, so a mismatch against the bench's shadow memory follows within a few accesses. A reset counter that is off by even one cycle changes the number of cycles `int_srst` is high, which is counted exactly. Mode bits that are not cleared by a soft reset appear on the first read of the mode byte after reset ends.

// File: rtl/ihb_pkg.sv
package ihb_pkg;

   // Mode byte bit positions (host visible)
   localparam int MB_SRST = 7;
   localparam int MB_PING = 4;
   localparam int MB_STEP = 1;
   localparam int MB_IND  = 0;

   // Writable mode bits other than the reset trigger
   localparam logic [7:0] MODE_WMASK = 8'h13;

   // Window offsets
   localparam logic [1:0] OFS_MODE = 2'd0;
   localparam logic [1:0] OFS_PHI  = 2'd1;
   localparam logic [1:0] OFS_PLO  = 2'd2;
   localparam logic [1:0] OFS_DATA = 2'd3;

   typedef struct packed {
      logic ping;
      logic step;
      logic ind;
   } mode_t;

endpackage

// File: rtl/ihb_mode_ctrl.sv
module ihb_mode_ctrl
   import ihb_pkg::*;
#(
   parameter int RST_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_mode,
   input  logic [7:0] wdata,
   output mode_t      mode,
   output logic       busy,
   output logic [7:0] mode_view
);

   localparam int CW = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         mode <= '0;
      end else if (busy) begin
         cnt <= cnt - CW'(1);
         if (cnt == CW'(1)) busy <= 1'b0;
      end else if (wr_mode) begin
         if (wdata[MB_SRST]) begin
            busy <= 1'b1;
            cnt  <= CW'(RST_CYCLES);
            mode <= '0;
         end else begin
            mode.ping <= wdata[MB_PING];
            mode.step <= wdata[MB_STEP];
            mode.ind  <= wdata[MB_IND];
         end
      end
   end

   always_comb begin
      mode_view          = 8'h00;
      mode_view[MB_SRST] = busy;
      mode_view[MB_PING] = mode.ping;
      mode_view[MB_STEP] = mode.step;
      mode_view[MB_IND]  = mode.ind;
   end

   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mode == '0)) else $error("mode kept during reset"); // R9

   AST_RST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_mode) |=> (mode == $past(mode))) else $error("write in reset"); // R10

endmodule

// File: rtl/ihb_addr_ptr.sv
module ihb_addr_ptr #(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ld_hi,
   input  logic          ld_lo,
   input  logic [7:0]    wdata,
   input  logic          step,
   output logic [AW-1:0] ptr,
   output logic [7:0]    hi_view,
   output logic [7:0]    lo_view
);

   localparam int HW = AW - 8;

   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 9..16");
   end

   logic unused_wbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (ld_hi) begin
         ptr[AW-1:8] <= wdata[HW-1:0];
      end else if (ld_lo) begin
         ptr[7:0] <= wdata;
      end else if (step) begin
         ptr <= ptr + AW'(1);
      end
   end

   if (HW < 8) begin : g_narrow_hi
      assign hi_view      = {{(8-HW){1'b0}}, ptr[AW-1:8]};
      assign unused_wbits = ^wdata[7:HW];
   end else begin : g_full_hi
      assign hi_view      = ptr[AW-1:8];
      assign unused_wbits = 1'b0;
   end
   assign lo_view = ptr[7:0];

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !ld_hi && !ld_lo && (&ptr)) |=> (ptr == '0))
      else $error("pointer wrap"); // R7

endmodule

// File: rtl/ihb_rd_path.sv
module ihb_rd_path
   import ihb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_acc,
   input  logic [1:0] ofs,
   input  logic       fetch,
   input  logic [7:0] mode_view,
   input  logic [7:0] hi_view,
   input  logic [7:0] lo_view,
   input  logic [7:0] int_rdata,
   output logic       rvalid,
   output logic [7:0] rdata
);

   logic       sel_int;
   logic [7:0] reg_q;
   logic [7:0] reg_d;

   always_comb begin
      unique case (ofs)
         OFS_MODE: reg_d = mode_view;
         OFS_PHI:  reg_d = hi_view;
         OFS_PLO:  reg_d = lo_view;
         default:  reg_d = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid  <= 1'b0;
         sel_int <= 1'b0;
         reg_q   <= 8'h00;
      end else begin
         rvalid <= rd_acc;
         if (rd_acc) begin
            sel_int <= fetch;
            reg_q   <= reg_d;
         end
      end
   end

   assign rdata = !rvalid ? 8'h00 : (sel_int ? int_rdata : reg_q);

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> rvalid) else $error("read not answered"); // R1

endmodule

// File: rtl/ihb_bridge.sv
module ihb_bridge
   import ihb_pkg::*;
#(
   parameter int AW         = 15,
   parameter int RST_CYCLES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    host_ofs,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   output logic          host_rvalid,
   output logic [AW-1:0] int_addr,
   output logic [7:0]    int_wdata,
   output logic          int_we,
   output logic          int_re,
   input  logic [7:0]    int_rdata,
   output logic          int_srst,
   output logic          ping_block
);

   mode_t      mode;
   logic       busy;
   logic [7:0] mode_view;
   logic [7:0] hi_view;
   logic [7:0] lo_view;
   logic       rd_acc;
   logic       wr_open;
   logic       data_ok;
   logic       step;

   assign rd_acc  = host_rd && !host_wr;
   assign wr_open = host_wr && !busy;
   assign data_ok = (host_ofs == OFS_DATA) && mode.ind && !busy;

   ihb_mode_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (wr_open && (host_ofs == OFS_MODE)),
      .wdata     (host_wdata),
      .mode      (mode),
      .busy      (busy),
      .mode_view (mode_view)
   );

   assign int_we = host_wr && data_ok;
   assign int_re = rd_acc && data_ok;
   assign step   = (int_we || int_re) && mode.step;

   ihb_addr_ptr #(.AW(AW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (busy),
      .ld_hi   (wr_open && (host_ofs == OFS_PHI)),
      .ld_lo   (wr_open && (host_ofs == OFS_PLO)),
      .wdata   (host_wdata),
      .step    (step),
      .ptr     (int_addr),
      .hi_view (hi_view),
      .lo_view (lo_view)
   );

   ihb_rd_path u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_acc    (rd_acc),
      .ofs       (host_ofs),
      .fetch     (int_re),
      .mode_view (mode_view),
      .hi_view   (hi_view),
      .lo_view   (lo_view),
      .int_rdata (int_rdata),
      .rvalid    (host_rvalid),
      .rdata     (host_rdata)
   );

   assign int_wdata  = host_wdata;
   assign int_srst   = busy;
   assign ping_block = mode.ping;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((int_we || int_re) && mode.step) |=> (int_addr == AW'($past(int_addr) + AW'(1))))
      else $error("step size"); // R6

   AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((int_we || int_re) && !mode.step) |=> $stable(int_addr))
      else $error("pointer moved"); // R6

   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      int_srst |-> !(int_we || int_re)) else $error("strobe in reset"); // R10

   AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.ind |-> !(int_we || int_re)) else $error("strobe in direct"); // R8

   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_rd) |=> !host_rvalid) else $error("read with write"); // R11

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_we && int_re)) else $error("two strobes"); // R11

endmodule

// File: tb/sim_ihb_bridge.sv
module sim_ihb_bridge;

   localparam int AW = 15;
   localparam int RC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    host_ofs = '0;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic [7:0]    host_wdata = '0;
   logic [7:0]    host_rdata;
   logic          host_rvalid;
   logic [AW-1:0] int_addr;
   logic [7:0]    int_wdata;
   logic          int_we;
   logic          int_re;
   logic [7:0]    int_rdata;
   logic          int_srst;
   logic          ping_block;

   always #5 clk = ~clk;

   ihb_bridge #(.AW(AW), .RST_CYCLES(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .host_ofs(host_ofs), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .int_addr(int_addr), .int_wdata(int_wdata),
      .int_we(int_we), .int_re(int_re), .int_rdata(int_rdata),
      .int_srst(int_srst), .ping_block(ping_block)
   );

   // Internal memory model: 256 bytes, aliased on the low address byte
   logic [7:0] mem [256];
   logic [7:0] mem_q = 8'h00;
   int strobes = 0;
   int srst_cycles = 0;

   always @(posedge clk) begin
      if (int_srst) begin
         mem[8'h17] <= 8'h07;
         mem[8'h18] <= 8'hD0;
      end else if (int_we) begin
         mem[int_addr[7:0]] <= int_wdata;
      end
      if (int_re) mem_q <= mem[int_addr[7:0]];
      if (int_we || int_re) strobes <= strobes + 1;
      if (int_srst) srst_cycles <= srst_cycles + 1;
   end
   assign int_rdata = mem_q;

   // Expected-state model
   int          checks = 0;
   int          errors = 0;
   logic [7:0]  m_mode = 8'h00;
   logic [14:0] m_ptr = '0;
   logic [7:0]  shadow [256];

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [1:0] o);
      case (o)
         2'd0: return m_mode;
         2'd1: return {1'b0, m_ptr[14:8]};
         2'd2: return m_ptr[7:0];
         default: return m_mode[0] ? shadow[m_ptr[7:0]] : 8'h00;
      endcase
   endfunction

   function automatic logic [14:0] next_ptr(input logic [14:0] p);
      return (m_mode[0] && m_mode[1]) ? p + 15'd1 : p;
   endfunction

   task automatic wr(input logic [1:0] o, input logic [7:0] d);
      @(negedge clk);
      host_ofs = o; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] o, output logic [7:0] d, output logic v);
      @(negedge clk);
      host_ofs = o; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata; v = host_rvalid;
   endtask

   task automatic m_wr(input logic [1:0] o, input logic [7:0] d);
      wr(o, d);
      case (o)
         2'd0: m_mode = d & 8'h13;
         2'd1: m_ptr[14:8] = d[6:0];
         2'd2: m_ptr[7:0] = d;
         default: if (m_mode[0]) begin
            shadow[m_ptr[7:0]] = d;
            m_ptr = next_ptr(m_ptr);
         end
      endcase
   endtask

   task automatic m_rd(input logic [1:0] o, input string req);
      logic [7:0] d;
      logic v;
      logic [7:0] e;
      e = exp_read(o);
      rd(o, d, v);
      check(req, {15'd0, v}, 16'd1);
      check(req, {8'd0, d}, {8'd0, e});
      if (o == 2'd3) m_ptr = next_ptr(m_ptr);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic v;
      int s0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state
      check("R2 srst", {15'd0, int_srst}, 16'd0);
      check("R2 ping", {15'd0, ping_block}, 16'd0);
      check("R2 strobes", {15'd0, int_we | int_re}, 16'd0);
      m_rd(2'd0, "R2 mode");
      m_rd(2'd1, "R2 ptr hi");
      m_rd(2'd2, "R2 ptr lo");

      // R3: only defined bits stick, ping drives output
      m_wr(2'd0, 8'h7F);
      m_rd(2'd0, "R3 mode view");
      check("R3 ping out", {15'd0, ping_block}, 16'd1);
      m_wr(2'd0, 8'h00);

      // R8: direct mode data port
      m_wr(2'd2, 8'h44);
      s0 = strobes;
      m_wr(2'd3, 8'hAA);
      m_rd(2'd3, "R8 read zero");
      check("R8 no strobe", 16'(strobes - s0), 16'd0);
      m_rd(2'd2, "R8 ptr kept");

      // R4/R6: fill memory with auto-step
      m_wr(2'd0, 8'h03);
      m_wr(2'd1, 8'h00);
      m_wr(2'd2, 8'h00);
      for (int i = 0; i < 256; i++) m_wr(2'd3, 8'(i) ^ 8'h5A);
      m_rd(2'd1, "R6 ptr hi after fill");
      m_rd(2'd2, "R6 ptr lo after fill");
      // R4: check write address and data directly
      @(negedge clk);
      host_ofs = 2'd3; host_wdata = 8'hC3; host_wr = 1'b1;
      #1;
      check("R4 we", {15'd0, int_we}, 16'd1);
      check("R4 addr", {1'b0, int_addr}, {1'b0, m_ptr});
      check("R4 wdata", {8'd0, int_wdata}, 16'h00C3);
      @(negedge clk);
      host_wr = 1'b0;
      shadow[m_ptr[7:0]] = 8'hC3;
      m_ptr = next_ptr(m_ptr);

      // R5: streamed reads
      m_wr(2'd2, 8'h10);
      for (int i = 0; i < 6; i++) m_rd(2'd3, "R5 stream read");

      // R6: no step when disabled
      m_wr(2'd0, 8'h01);
      m_rd(2'd3, "R6 hold read a");
      m_rd(2'd3, "R6 hold read b");
      m_rd(2'd2, "R6 hold ptr");

      // R7 / R1: top of space and high byte width
      m_wr(2'd0, 8'h03);
      m_wr(2'd1, 8'hFF);
      m_wr(2'd2, 8'hFF);
      m_rd(2'd1, "R1 hi bit7 zero");
      m_wr(2'd3, 8'h21);
      m_rd(2'd1, "R7 wrap hi");
      m_rd(2'd2, "R7 wrap lo");

      // R11: write wins over read
      @(negedge clk);
      host_ofs = 2'd2; host_wdata = 8'h33; host_wr = 1'b1; host_rd = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      m_ptr[7:0] = 8'h33;
      check("R11 no rvalid", {15'd0, host_rvalid}, 16'd0);
      m_rd(2'd2, "R11 write took");

      // Random traffic: R1 R5 R6
      for (int n = 0; n < 600; n++) begin
         logic [1:0] o;
         logic [7:0] r;
         o = 2'($urandom);
         r = 8'($urandom);
         if (o == 2'd0) r = r & 8'h13;
         if ($urandom % 2 == 0) m_wr(o, r);
         else m_rd(o, "R1 R5 R6 random");
      end

      // R9/R10: soft reset
      m_wr(2'd0, 8'h13);
      m_wr(2'd2, 8'h5C);
      s0 = srst_cycles;
      wr(2'd0, 8'h80);
      rd(2'd0, d, v);
      check("R9 mode in reset", {8'd0, d}, 16'h0080);
      wr(2'd2, 8'h55);
      wr(2'd0, 8'h03);
      repeat (RC + 2) @(negedge clk);
      m_mode = 8'h00;
      m_ptr = '0;
      shadow[8'h17] = 8'h07;
      shadow[8'h18] = 8'hD0;
      check("R9 srst length", 16'(srst_cycles - s0), 16'(RC));
      check("R9 ping cleared", {15'd0, ping_block}, 16'd0);
      m_rd(2'd0, "R9 R10 mode after");
      m_rd(2'd2, "R9 R10 ptr after");

      // Retry register default through streamed reads (R5)
      m_wr(2'd0, 8'h03);
      m_wr(2'd2, 8'h17);
      m_rd(2'd3, "R5 retry hi");
      m_rd(2'd3, "R5 retry lo");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule